// File: doc/BRIEF.md
# Sync Polarity and Blanking Discriminator

This block sits at the front of a video input path. It takes horizontal and vertical sync from one of three sources, selected by a small control field. From these it gives active-high sync pulses, whatever polarity is wired. It works out the polarity of each sync by itself: it counts pixel clocks in the high run and the low run of each period, and takes the shorter run as the pulse. From the normalised syncs it marks the field parity of an interlaced source. It does this by checking where, within the current line, each vertical pulse begins.

The block also handles the data-enable (blanking) lines. Their sense can be flipped by one control bit. In composite mode only the horizontal enable line carries information. An enable gap longer than a programmable number of clocks is then vertical blanking, and a shorter gap is horizontal blanking. A presence monitor raises a loss flag when the selected horizontal sync shows no edge within a programmable timeout.

Each tracker is a named state machine. Polarity tracker: `PT_WAIT` goes to `PT_HIGH` on the first rise. `PT_HIGH` goes to `PT_LOW` on a fall. `PT_LOW` goes back to `PT_HIGH` on a rise, and the verdict is taken then. Blanking splitter: `BS_ACTIVE` goes to `BS_HBLANK` when enable drops, or straight to `BS_VBLANK` if the threshold is zero. `BS_HBLANK` goes to `BS_VBLANK` once the gap exceeds the threshold. Both `BS_HBLANK` and `BS_VBLANK` return to `BS_ACTIVE` when enable returns. Presence monitor: `PS_ABSENT` goes to `PS_PRESENT` on any edge. `PS_PRESENT` goes to `PS_ABSENT` when the timeout is reached.

Top module: `sync_polarity_disc`

## Requirements
- R1: `src_sel` 0, 1 and 2 pick sync pair 0, 1 and 2 (bit n of `hs_in`/`vs_in`); value 3 picks pair 2. The chosen pair and all control inputs are registered once before use.
- R2: After each complete period (a rising edge that closes a low run), a polarity flag is set to 1 if the high run was longer than the low run, and to 0 otherwise (equal runs give 0). The flag changes in the cycle after that rising edge. It is 0 from reset until the first complete period.
- R3: `hsync_out`/`vsync_out` equal the registered selected sync XOR its polarity flag, so the pulse is always active high.
- R4: At a rising edge of normalised vsync, `field_odd` is loaded with 1 if twice the clock count since the last normalised hsync rising edge is at least the last measured line length, and with 0 otherwise. An edge that coincides with an hsync rising edge counts as position 0. `field_odd` is 0 after reset.
- R5: Outside composite mode, `henable_out` and `venable_out` equal the registered `blank_h_in` and `blank_v_in`, each XOR the registered `blank_invert`.
- R6: In composite mode, `venable_out` goes low one cycle after an enable gap of the horizontal line grows beyond `vblank_thresh` clocks. It stays low until the cycle after enable returns. A gap of exactly `vblank_thresh` clocks leaves it high, and `blank_v_in` has no effect.
- R7: `sync_lost` is 1 after reset. It is set once `loss_timeout` consecutive cycles pass with no edge on the registered selected hsync.
- R8: `sync_lost` clears in the cycle after the next edge of the registered selected hsync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Source pair select |
| hs_in | input | 3 | Horizontal sync, one bit per source |
| vs_in | input | 3 | Vertical sync, one bit per source |
| blank_h_in | input | 1 | Horizontal enable, or composite enable |
| blank_v_in | input | 1 | Vertical enable (held high in composite use) |
| blank_invert | input | 1 | Invert the sense of both enable inputs |
| composite_en | input | 1 | Derive both enables from the horizontal line |
| vblank_thresh | input | 12 | Gap length above which blanking is vertical |
| loss_timeout | input | 12 | Edge-free cycles before sync is declared lost |
| hsync_out | output | 1 | Normalised horizontal sync |
| vsync_out | output | 1 | Normalised vertical sync |
| hpol_low | output | 1 | Horizontal sync found active low |
| vpol_low | output | 1 | Vertical sync found active low |
| field_odd | output | 1 | Field parity flag |
| henable_out | output | 1 | Horizontal enable |
| venable_out | output | 1 | Vertical enable |
| sync_lost | output | 1 | Horizontal sync absent |

## Verification
The hardest case is a vertical leading edge that lands in the very clock where a horizontal leading edge also arrives. There the field logic must read position zero, not the full line length that the line counter holds in that cycle. The bench sets up a vertical period of ten and a half lines. Its vertical pulses then alternate between mid-line and exactly on a horizontal leading edge, so the field flag must toggle between 1 and 0. A behavioural model checks the flag on every clock. A second coincidence, a polarity flip that makes a spurious normalised edge in the same cycle as a real one, is covered by the same model in the first periods after reset.

// File: rtl/sync_disc_pkg.sv
package sync_disc_pkg;

    typedef enum logic [1:0] {
        PT_WAIT = 2'd0,
        PT_HIGH = 2'd1,
        PT_LOW  = 2'd2
    } pol_state_e;

    typedef enum logic [1:0] {
        BS_ACTIVE = 2'd0,
        BS_HBLANK = 2'd1,
        BS_VBLANK = 2'd2
    } blank_state_e;

    typedef enum logic {
        PS_ABSENT  = 1'b0,
        PS_PRESENT = 1'b1
    } pres_state_e;

endpackage

// File: rtl/sync_pol_tracker.sv
module sync_pol_tracker
    import sync_disc_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    output logic pol_low_o
);
    localparam logic [CNT_W-1:0] CMAX = '1;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    pol_state_e       st_q, st_d;
    logic             prev_q;
    logic [CNT_W-1:0] hi_q, hi_d, lo_q, lo_d;
    logic             pol_q, pol_d;
    logic             rise, fall;

    assign rise = sync_i & ~prev_q;
    assign fall = ~sync_i & prev_q;

    always_comb begin
        st_d  = st_q;
        hi_d  = hi_q;
        lo_d  = lo_q;
        pol_d = pol_q;
        unique case (st_q)
            PT_WAIT: begin
                if (rise) begin
                    st_d = PT_HIGH;
                    hi_d = ONE;
                end
            end
            PT_HIGH: begin
                if (fall) begin
                    st_d = PT_LOW;
                    lo_d = ONE;
                end else if (sync_i && hi_q != CMAX) begin
                    hi_d = hi_q + ONE;
                end
            end
            PT_LOW: begin
                if (rise) begin
                    pol_d = (hi_q > lo_q);
                    st_d  = PT_HIGH;
                    hi_d  = ONE;
                    lo_d  = '0;
                end else if (lo_q != CMAX) begin
                    lo_d = lo_q + ONE;
                end
            end
            default: st_d = PT_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= PT_WAIT;
            prev_q <= 1'b0;
            hi_q   <= '0;
            lo_q   <= '0;
            pol_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            prev_q <= sync_i;
            hi_q   <= hi_d;
            lo_q   <= lo_d;
            pol_q  <= pol_d;
        end
    end

    always_comb begin
        pol_low_o = pol_q;
    end

    // R2
    pol_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pol_q) |-> ($past(st_q) == PT_LOW && $past(sync_i)));

endmodule

// File: rtl/sync_field_detect.sv
module sync_field_detect #(
    parameter int CNT_W = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hn_i,
    input  logic vn_i,
    output logic field_o
);
    localparam logic [CNT_W-1:0] CMAX = '1;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic             hn_d, vn_d;
    logic [CNT_W-1:0] hpos_q, len_q, pos;
    logic [CNT_W:0]   pos2;
    logic             h_lead, v_lead, field_q;

    assign h_lead = hn_i & ~hn_d;
    assign v_lead = vn_i & ~vn_d;
    assign pos    = h_lead ? '0 : hpos_q;
    assign pos2   = {pos, 1'b0};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hn_d    <= 1'b0;
            vn_d    <= 1'b0;
            hpos_q  <= '0;
            len_q   <= '0;
            field_q <= 1'b0;
        end else begin
            hn_d <= hn_i;
            vn_d <= vn_i;
            if (h_lead) begin
                len_q  <= hpos_q;
                hpos_q <= ONE;
            end else if (hpos_q != CMAX) begin
                hpos_q <= hpos_q + ONE;
            end
            if (v_lead) begin
                field_q <= (pos2 >= {1'b0, len_q});
            end
        end
    end

    assign field_o = field_q;

    // R4
    field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(field_q) |-> $past(vn_i && !vn_d));

endmodule

// File: rtl/blank_splitter.sv
module blank_splitter
    import sync_disc_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             vraw_i,
    input  logic             comp_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             hen_o,
    output logic             ven_o
);
    localparam logic [CNT_W-1:0] CMAX = '1;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    blank_state_e     st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            BS_ACTIVE: begin
                if (!en_i) begin
                    cnt_d = ONE;
                    st_d  = (ONE > thr_i) ? BS_VBLANK : BS_HBLANK;
                end
            end
            BS_HBLANK: begin
                if (en_i) begin
                    st_d = BS_ACTIVE;
                end else begin
                    if (cnt_q != CMAX) cnt_d = cnt_q + ONE;
                    if (cnt_d > thr_i) st_d = BS_VBLANK;
                end
            end
            BS_VBLANK: begin
                if (en_i) st_d = BS_ACTIVE;
            end
            default: st_d = BS_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= BS_ACTIVE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        hen_o = en_i;
        ven_o = comp_i ? (st_q != BS_VBLANK) : vraw_i;
    end

    // R6
    vb_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BS_VBLANK) |=> (st_q == BS_VBLANK || st_q == BS_ACTIVE));

    // R6
    vb_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BS_VBLANK && $past(st_q) != BS_VBLANK) |-> !$past(en_i));

endmodule

// File: rtl/sync_presence.sv
module sync_presence
    import sync_disc_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_i,
    input  logic [CNT_W-1:0] tmo_i,
    output logic             lost_o
);
    localparam logic [CNT_W-1:0] CMAX = '1;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    pres_state_e      st_q, st_d;
    logic             prev_q, edge_seen;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    assign edge_seen = sync_i ^ prev_q;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (edge_seen) begin
            cnt_d = '0;
            st_d  = PS_PRESENT;
        end else begin
            if (cnt_q != CMAX) cnt_d = cnt_q + ONE;
            unique case (st_q)
                PS_PRESENT: if (cnt_d >= tmo_i) st_d = PS_ABSENT;
                PS_ABSENT:  st_d = PS_ABSENT;
                default:    st_d = PS_ABSENT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= PS_ABSENT;
            prev_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            st_q   <= st_d;
            prev_q <= sync_i;
            cnt_q  <= cnt_d;
        end
    end

    always_comb begin
        lost_o = (st_q == PS_ABSENT);
    end

    // R8
    lost_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lost_o) |-> $past(sync_i != prev_q));

    // R7
    lost_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost_o) |-> $past(sync_i == prev_q));

endmodule

// File: rtl/sync_polarity_disc.sv
module sync_polarity_disc #(
    parameter int NSRC  = 3,
    parameter int CNT_W = 12,
    localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] src_sel,
    input  logic [NSRC-1:0]  hs_in,
    input  logic [NSRC-1:0]  vs_in,
    input  logic             blank_h_in,
    input  logic             blank_v_in,
    input  logic             blank_invert,
    input  logic             composite_en,
    input  logic [CNT_W-1:0] vblank_thresh,
    input  logic [CNT_W-1:0] loss_timeout,
    output logic             hsync_out,
    output logic             vsync_out,
    output logic             hpol_low,
    output logic             vpol_low,
    output logic             field_odd,
    output logic             henable_out,
    output logic             venable_out,
    output logic             sync_lost
);
    localparam logic [SEL_W-1:0] LAST = SEL_W'(NSRC - 1);

    logic [SEL_W-1:0] idx;
    logic             hs_r, vs_r, bh_r, bv_r, inv_r, comp_r;
    logic [CNT_W-1:0] thr_r, tmo_r;
    logic [1:0]       raw, pol, norm;

    assign idx = (int'(src_sel) >= NSRC) ? LAST : src_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_r   <= 1'b0;
            vs_r   <= 1'b0;
            bh_r   <= 1'b0;
            bv_r   <= 1'b0;
            inv_r  <= 1'b0;
            comp_r <= 1'b0;
            thr_r  <= '0;
            tmo_r  <= '0;
        end else begin
            hs_r   <= hs_in[idx];
            vs_r   <= vs_in[idx];
            bh_r   <= blank_h_in;
            bv_r   <= blank_v_in;
            inv_r  <= blank_invert;
            comp_r <= composite_en;
            thr_r  <= vblank_thresh;
            tmo_r  <= loss_timeout;
        end
    end

    assign raw = {vs_r, hs_r};

    for (genvar g = 0; g < 2; g++) begin : g_pol
        sync_pol_tracker #(.CNT_W(CNT_W)) u_pol (
            .clk       (clk),
            .rst_n     (rst_n),
            .sync_i    (raw[g]),
            .pol_low_o (pol[g])
        );
    end

    assign norm = raw ^ pol;

    sync_field_detect #(.CNT_W(CNT_W)) u_field (
        .clk     (clk),
        .rst_n   (rst_n),
        .hn_i    (norm[0]),
        .vn_i    (norm[1]),
        .field_o (field_odd)
    );

    blank_splitter #(.CNT_W(CNT_W)) u_blank (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (bh_r ^ inv_r),
        .vraw_i (bv_r ^ inv_r),
        .comp_i (comp_r),
        .thr_i  (thr_r),
        .hen_o  (henable_out),
        .ven_o  (venable_out)
    );

    sync_presence #(.CNT_W(CNT_W)) u_pres (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (hs_r),
        .tmo_i  (tmo_r),
        .lost_o (sync_lost)
    );

    assign hsync_out = norm[0];
    assign vsync_out = norm[1];
    assign hpol_low  = pol[0];
    assign vpol_low  = pol[1];

endmodule

// File: tb/test_sync_polarity_disc.sv
module test_sync_polarity_disc;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  src_sel = '0;
    logic [2:0]  hs_in = '0, vs_in = '0;
    logic        blank_h_in = 1'b0, blank_v_in = 1'b0;
    logic        blank_invert = 1'b0, composite_en = 1'b0;
    logic [11:0] vblank_thresh = '0, loss_timeout = '0;
    logic        hsync_out, vsync_out, hpol_low, vpol_low, field_odd;
    logic        henable_out, venable_out, sync_lost;

    sync_polarity_disc i_sync_polarity_disc (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .hs_in(hs_in), .vs_in(vs_in),
        .blank_h_in(blank_h_in), .blank_v_in(blank_v_in), .blank_invert(blank_invert),
        .composite_en(composite_en), .vblank_thresh(vblank_thresh), .loss_timeout(loss_timeout),
        .hsync_out(hsync_out), .vsync_out(vsync_out), .hpol_low(hpol_low), .vpol_low(vpol_low),
        .field_odd(field_odd), .henable_out(henable_out), .venable_out(venable_out),
        .sync_lost(sync_lost)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int vectors = 0, miscompares = 0;
    bit started = 0;

    task automatic cmp(input string tag, input string nm, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, nm, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_hs, m_vs, m_bh, m_bv, m_inv, m_comp, m_thr, m_tmo;
    int m_st[2], m_hi[2], m_lo[2], m_pol[2], m_prev[2];
    int m_hnd, m_vnd, m_hpos, m_len, m_field;
    int m_bst, m_bcnt;
    int m_lost, m_pcnt, m_pprev;
    int hn, vn, hl, vl, s, en, sidx;

    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_hs = 0; m_vs = 0; m_bh = 0; m_bv = 0; m_inv = 0; m_comp = 0; m_thr = 0; m_tmo = 0;
            for (int k = 0; k < 2; k++) begin
                m_st[k] = 0; m_hi[k] = 0; m_lo[k] = 0; m_pol[k] = 0; m_prev[k] = 0;
            end
            m_hnd = 0; m_vnd = 0; m_hpos = 0; m_len = 0; m_field = 0;
            m_bst = 0; m_bcnt = 0; m_lost = 1; m_pcnt = 0; m_pprev = 0;
        end else begin
            // field parity from normalised edges
            hn = m_hs ^ m_pol[0];
            vn = m_vs ^ m_pol[1];
            hl = (hn == 1 && m_hnd == 0) ? 1 : 0;
            vl = (vn == 1 && m_vnd == 0) ? 1 : 0;
            if (vl == 1) m_field = (2 * ((hl == 1) ? 0 : m_hpos) >= m_len) ? 1 : 0;
            if (hl == 1) begin m_len = m_hpos; m_hpos = 1; end
            else if (m_hpos < 4095) m_hpos++;
            m_hnd = hn; m_vnd = vn;
            // polarity from run lengths
            for (int k = 0; k < 2; k++) begin
                s = (k == 0) ? m_hs : m_vs;
                if (m_st[k] == 0) begin
                    if (s == 1 && m_prev[k] == 0) begin m_st[k] = 1; m_hi[k] = 1; end
                end else if (m_st[k] == 1) begin
                    if (s == 0 && m_prev[k] == 1) begin m_st[k] = 2; m_lo[k] = 1; end
                    else if (s == 1 && m_hi[k] < 4095) m_hi[k]++;
                end else begin
                    if (s == 1 && m_prev[k] == 0) begin
                        m_pol[k] = (m_hi[k] > m_lo[k]) ? 1 : 0;
                        m_st[k] = 1; m_hi[k] = 1; m_lo[k] = 0;
                    end else if (m_lo[k] < 4095) m_lo[k]++;
                end
                m_prev[k] = s;
            end
            // blanking classification
            en = m_bh ^ m_inv;
            case (m_bst)
                0: if (en == 0) begin m_bcnt = 1; m_bst = (1 > m_thr) ? 2 : 1; end
                1: if (en == 1) m_bst = 0;
                   else begin
                       if (m_bcnt < 4095) m_bcnt++;
                       if (m_bcnt > m_thr) m_bst = 2;
                   end
                default: if (en == 1) m_bst = 0;
            endcase
            // sync presence
            if (m_hs != m_pprev) begin m_pcnt = 0; m_lost = 0; end
            else begin
                if (m_pcnt < 4095) m_pcnt++;
                if (m_lost == 0 && m_pcnt >= m_tmo) m_lost = 1;
            end
            m_pprev = m_hs;
            // input register stage
            sidx = (src_sel >= 3) ? 2 : int'(src_sel);
            m_hs = hs_in[sidx]; m_vs = vs_in[sidx];
            m_bh = blank_h_in; m_bv = blank_v_in; m_inv = blank_invert;
            m_comp = composite_en; m_thr = vblank_thresh; m_tmo = loss_timeout;
        end
    end

    always @(negedge clk) begin
        if (started) begin
            cmp("R1/R3", "hsync_out", hsync_out, m_hs ^ m_pol[0]);
            cmp("R1/R3", "vsync_out", vsync_out, m_vs ^ m_pol[1]);
            cmp("R2", "hpol_low", hpol_low, m_pol[0]);
            cmp("R2", "vpol_low", vpol_low, m_pol[1]);
            cmp("R4", "field_odd", field_odd, m_field);
            cmp("R5", "henable_out", henable_out, m_bh ^ m_inv);
            if (m_comp == 1) cmp("R6", "venable_out", venable_out, (m_bst != 2) ? 1 : 0);
            else             cmp("R5", "venable_out", venable_out, m_bv ^ m_inv);
            cmp("R7/R8", "sync_lost", sync_lost, m_lost);
        end
    end

    // ---------------- stimulus generator ----------------
    int pc = 0, gpair = 0;
    int hper = 20, hwid = 3, hlow = 0, vper = 210, vwid = 40, vlow = 1;
    int bper = 20, bhw = 5, bframe = 210, bvw = 30, binv = 0, vtog = 0;

    task automatic drive_cycle();
        int hv, vv, e, vb;
        hv = ((hper > 0) ? (((pc % hper) < hwid) ? 1 : 0) : 0) ^ hlow;
        vv = ((vper > 0) ? (((pc % vper) < vwid) ? 1 : 0) : 0) ^ vlow;
        vb = ((pc % bframe) < bvw) ? 1 : 0;
        e  = (((pc % bper) < bhw) || vb == 1) ? 0 : 1;
        hs_in = '0; vs_in = '0;
        hs_in[gpair] = hv[0];
        vs_in[gpair] = vv[0];
        blank_h_in = e[0] ^ binv[0];
        if (vtog == 1) blank_v_in = pc[0];
        else           blank_v_in = (vb == 0) ^ binv[0];
    endtask

    task automatic run(input int n);
        repeat (n) begin
            @(posedge clk); #1;
            drive_cycle();
            pc++;
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        vectors++; miscompares++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        vblank_thresh = 12'd8;
        loss_timeout  = 12'd50;
        repeat (4) @(posedge clk);
        // reset state, checked by the model compare (R7: lost after reset)
        #1;
        cmp("R7", "sync_lost at reset", sync_lost, 1);
        cmp("R2", "hpol_low at reset", hpol_low, 0);
        cmp("R4", "field_odd at reset", field_odd, 0);
        rst_n = 1'b1;
        // phase A: pair 0, active-high H, active-low V, 10.5 lines per field (R4 coincidence)
        src_sel = 2'd0; gpair = 0; pc = 0;
        run(1500);
        cmp("R2", "pair0 H active high", hpol_low, 0);
        cmp("R2", "pair0 V active low", vpol_low, 1);
        // phase B: pair 1, inverted polarities and inverted enables (R1, R5)
        src_sel = 2'd1; gpair = 1; hlow = 1; vlow = 0; binv = 1; blank_invert = 1'b1; pc = 0;
        run(1500);
        cmp("R1", "pair1 H polarity seen", hpol_low, 1);
        cmp("R1", "pair1 V polarity seen", vpol_low, 0);
        // mismatched invert: enables come out inverted (R5)
        blank_invert = 1'b0;
        run(300);
        // phase C: select 3 -> pair 2, composite mode, gap of exactly threshold (R6 boundary)
        src_sel = 2'd3; gpair = 2; composite_en = 1'b1; blank_invert = 1'b0; binv = 0;
        vtog = 1; bhw = 8; bvw = 0; pc = 0;
        run(600);
        cmp("R6", "gap equal to threshold keeps venable", venable_out, 1);
        // gap one longer than threshold, plus a real vertical gap
        bhw = 9; bvw = 30; pc = 0;
        run(600);
        cmp("R1", "select 3 maps to pair 2", sync_lost, 0);
        // threshold zero: any gap is vertical
        vblank_thresh = 12'd0;
        run(300);
        vblank_thresh = 12'd8;
        // phase D: equal duty on both syncs (R2)
        composite_en = 1'b0; vtog = 0; bhw = 5;
        hper = 10; hwid = 5; hlow = 0; vper = 100; vwid = 50; vlow = 0; pc = 0;
        run(600);
        cmp("R2", "equal H duty gives active high", hpol_low, 0);
        cmp("R2", "equal V duty gives active high", vpol_low, 0);
        // phase E: horizontal sync removed (R7), then restored (R8)
        hper = 0;
        run(120);
        cmp("R7", "no edges sets lost", sync_lost, 1);
        hper = 20; hwid = 3; pc = 0;
        run(40);
        cmp("R8", "edges clear lost", sync_lost, 0);
        run(10);
        summary();
        $finish;
    end

endmodule